// File: doc/BRIEF.md
# Cache Slice Return Sequencer

This block sits between the memory side of one cache slice and its reply path. It takes in data coming back from memory and handles one returned request at a time. A returned request can come from three places: the read-return queue, the write-return queue, or a chain of merged requests that a miss-merging register wants replayed. When the block is idle, a chain entry goes first, then a read return, then a write return.

Each memory return is announced to the miss-merging register on a notify port. If that register reports that the line activates a chain of merged requests, the memory return is consumed without being held. The chain's entries are then replayed through the chain port in its place.

A held read is handled in stages. First it is sent as a reply, and in the same cycle it fills the cache. If the fill evicts a line, the block then sends a writeback of that line. It retries the writeback every cycle until the writeback queue has room, and it never repeats the reply or the fill while doing so. A held write is only replied to. On release, a one-cycle completion pulse carries the request's id so that miss tracking can be updated.

Top module: `fill_wb_seq`

## Requirements
- R1: While `rst` is high, no queue is popped and nothing is pushed. After reset the block holds no request.
- R2: A new request is loaded only when none is held, with at most one pop per cycle. The order is chain entry (`chain_valid`) first, then read return, then write return. While a request is held, no further source is popped.
- R3: Every pop of a memory return raises `notify_valid` in the same cycle with that return's address. If `notify_hit` answers high, the return produces no reply, and the chain entries that follow are served instead.
- R4: A held read is replied to (`reply_push` with its id, address and `reply_wr`=0). In the same cycle, `fill_req` is raised with the address aligned down to `LINE_BYTES`.
- R5: While `reply_full` is high, a held request produces no reply and no fill, and it stays held.
- R6: A held write is replied to with `reply_wr`=1. It raises no fill and is released in the cycle of the reply.
- R7: When `evict_valid` is high during a fill, the block pushes one writeback. It carries `evict_addr` aligned down to the line, `wb_size`=`LINE_BYTES` and `wb_write`=1. The push is withheld while `wb_full` is high, and the reply and fill are not repeated during the wait.
- R8: A read is released only after its reply and any needed writeback have both been pushed. `done_valid` pulses for one cycle after release with the request's id. A pending writeback exists only while a request is held.
- R9: `reply_push` is never high while `reply_full` is high, and `wb_push` is never high while `wb_full` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_ret_valid | input | 1 | Read-return queue not empty |
| rd_ret_id | input | ID_W | Head read-return id |
| rd_ret_addr | input | ADDR_W | Head read-return address |
| rd_ret_pop | output | 1 | Pop the read-return queue |
| wr_ret_valid | input | 1 | Write-return queue not empty |
| wr_ret_id | input | ID_W | Head write-return id |
| wr_ret_addr | input | ADDR_W | Head write-return address |
| wr_ret_pop | output | 1 | Pop the write-return queue |
| chain_valid | input | 1 | Active merge chain has an entry |
| chain_id | input | ID_W | Chain entry id |
| chain_addr | input | ADDR_W | Chain entry address |
| chain_wr | input | 1 | Chain entry is a write |
| chain_pop | output | 1 | Take the chain entry |
| notify_valid | output | 1 | A memory return was popped |
| notify_addr | output | ADDR_W | Address of that return |
| notify_hit | input | 1 | Merge register activated a chain for it |
| reply_full | input | 1 | Reply queue full |
| reply_push | output | 1 | Push a reply |
| reply_id | output | ID_W | Reply id |
| reply_addr | output | ADDR_W | Reply address |
| reply_wr | output | 1 | Reply belongs to a write |
| fill_req | output | 1 | Fill the cache line |
| fill_addr | output | ADDR_W | Line-aligned fill address |
| evict_valid | input | 1 | Fill evicted a dirty line |
| evict_addr | input | ADDR_W | Evicted line address |
| wb_full | input | 1 | Writeback queue full |
| wb_push | output | 1 | Push a writeback |
| wb_addr | output | ADDR_W | Line-aligned writeback address |
| wb_size | output | SIZE_W | Writeback size in bytes |
| wb_write | output | 1 | Writeback tagged as write data |
| done_valid | output | 1 | Release pulse |
| done_id | output | ID_W | Released request id |

## Verification
The bench checks source order with several queues loaded at once. A design with the wrong order would reply in another order, and a design that ignored the hold would pop a second return while one is still held. It checks a memory return that hits the merge register; a design that held that return would send a reply that should not exist. It stalls the reply queue, and then separately stalls the writeback queue after an eviction. A design that got these wrong would push into a full queue, send the reply or fill twice during the retry, or pulse completion before the writeback left. It also checks the line alignment of the fill and writeback addresses and the writeback size.

// File: rtl/fwseq_pkg.sv
package fwseq_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_CHAIN = 2'd1,
    SRC_RD    = 2'd2,
    SRC_WR    = 2'd3
  } src_e;
endpackage

// File: rtl/fwseq_src_arb.sv
module fwseq_src_arb
  import fwseq_pkg::*;
(
  input  logic rst,
  input  logic hold_v,
  input  logic chain_valid,
  input  logic rd_valid,
  input  logic wr_valid,
  input  logic notify_hit,
  output src_e src,
  output logic chain_pop,
  output logic rd_pop,
  output logic wr_pop,
  output logic load
);
  always_comb begin
    src = SRC_NONE;
    if (!rst && !hold_v) begin
      if (chain_valid)   src = SRC_CHAIN;
      else if (rd_valid) src = SRC_RD;
      else if (wr_valid) src = SRC_WR;
    end
    chain_pop = (src == SRC_CHAIN);
    rd_pop    = (src == SRC_RD);
    wr_pop    = (src == SRC_WR);
    // a memory return that activates a chain is consumed, not held
    load      = chain_pop || ((rd_pop || wr_pop) && !notify_hit);
  end
endmodule

// File: rtl/fwseq_serve.sv
module fwseq_serve #(
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 6,
  parameter int LINE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ID_W-1:0]   load_id,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_wr,
  input  logic              reply_full,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              wb_full,
  output logic              reply_push,
  output logic [ID_W-1:0]   reply_id,
  output logic [ADDR_W-1:0] reply_addr,
  output logic              reply_wr,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              wb_push,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id,
  output logic              hold_v,
  output logic              wb_pend
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [ID_W-1:0]   h_id;
  logic [ADDR_W-1:0] h_addr;
  logic              h_wr;
  logic              replied;
  logic [ADDR_W-1:0] wb_addr_r;
  logic              release_now;

  always_comb begin
    reply_push  = hold_v && !replied && !reply_full;
    reply_id    = h_id;
    reply_addr  = h_addr;
    reply_wr    = h_wr;
    fill_req    = reply_push && !h_wr;
    fill_addr   = {h_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    wb_push     = wb_pend && !wb_full;
    wb_addr     = wb_addr_r;
    release_now = (reply_push && (h_wr || !evict_valid)) || wb_push;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v     <= 1'b0;
      wb_pend    <= 1'b0;
      replied    <= 1'b0;
      done_valid <= 1'b0;
      done_id    <= '0;
      h_id       <= '0;
      h_addr     <= '0;
      h_wr       <= 1'b0;
      wb_addr_r  <= '0;
    end else begin
      done_valid <= release_now;
      if (release_now) begin
        done_id <= h_id;
        hold_v  <= 1'b0;
        wb_pend <= 1'b0;
        replied <= 1'b0;
      end else if (reply_push) begin
        // read whose fill evicted a line: keep it until the writeback leaves
        replied   <= 1'b1;
        wb_pend   <= 1'b1;
        wb_addr_r <= {evict_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end
      if (load) begin
        hold_v <= 1'b1;
        h_id   <= load_id;
        h_addr <= load_addr;
        h_wr   <= load_wr;
      end
    end
  end
endmodule

// File: rtl/fill_wb_seq.sv
module fill_wb_seq
  import fwseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 6,
  parameter int LINE_BYTES = 128,
  localparam int SIZE_W    = $clog2(LINE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_ret_valid,
  input  logic [ID_W-1:0]   rd_ret_id,
  input  logic [ADDR_W-1:0] rd_ret_addr,
  output logic              rd_ret_pop,
  input  logic              wr_ret_valid,
  input  logic [ID_W-1:0]   wr_ret_id,
  input  logic [ADDR_W-1:0] wr_ret_addr,
  output logic              wr_ret_pop,
  input  logic              chain_valid,
  input  logic [ID_W-1:0]   chain_id,
  input  logic [ADDR_W-1:0] chain_addr,
  input  logic              chain_wr,
  output logic              chain_pop,
  output logic              notify_valid,
  output logic [ADDR_W-1:0] notify_addr,
  input  logic              notify_hit,
  input  logic              reply_full,
  output logic              reply_push,
  output logic [ID_W-1:0]   reply_id,
  output logic [ADDR_W-1:0] reply_addr,
  output logic              reply_wr,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              wb_full,
  output logic              wb_push,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [SIZE_W-1:0] wb_size,
  output logic              wb_write,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id
);
  src_e              src;
  logic              load;
  logic              hold_v;
  logic              wb_pend;
  logic [ID_W-1:0]   ld_id;
  logic [ADDR_W-1:0] ld_addr;
  logic              ld_wr;

  fwseq_src_arb u_arb (
    .rst         (rst),
    .hold_v      (hold_v),
    .chain_valid (chain_valid),
    .rd_valid    (rd_ret_valid),
    .wr_valid    (wr_ret_valid),
    .notify_hit  (notify_hit),
    .src         (src),
    .chain_pop   (chain_pop),
    .rd_pop      (rd_ret_pop),
    .wr_pop      (wr_ret_pop),
    .load        (load)
  );

  always_comb begin
    case (src)
      SRC_CHAIN: begin ld_id = chain_id;  ld_addr = chain_addr;  ld_wr = chain_wr; end
      SRC_WR:    begin ld_id = wr_ret_id; ld_addr = wr_ret_addr; ld_wr = 1'b1;     end
      default:   begin ld_id = rd_ret_id; ld_addr = rd_ret_addr; ld_wr = 1'b0;     end
    endcase
    notify_valid = rd_ret_pop || wr_ret_pop;
    notify_addr  = ld_addr;
    wb_size      = SIZE_W'(LINE_BYTES);
    wb_write     = 1'b1;
  end

  fwseq_serve #(
    .ADDR_W     (ADDR_W),
    .ID_W       (ID_W),
    .LINE_BYTES (LINE_BYTES)
  ) u_serve (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .load_id     (ld_id),
    .load_addr   (ld_addr),
    .load_wr     (ld_wr),
    .reply_full  (reply_full),
    .evict_valid (evict_valid),
    .evict_addr  (evict_addr),
    .wb_full     (wb_full),
    .reply_push  (reply_push),
    .reply_id    (reply_id),
    .reply_addr  (reply_addr),
    .reply_wr    (reply_wr),
    .fill_req    (fill_req),
    .fill_addr   (fill_addr),
    .wb_push     (wb_push),
    .wb_addr     (wb_addr),
    .done_valid  (done_valid),
    .done_id     (done_id),
    .hold_v      (hold_v),
    .wb_pend     (wb_pend)
  );
endmodule

// File: rtl/fwseq_chk.sv
module fwseq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_ret_valid,
  input logic              rd_ret_pop,
  input logic              wr_ret_pop,
  input logic              chain_valid,
  input logic              chain_pop,
  input logic              notify_valid,
  input logic              reply_full,
  input logic              reply_push,
  input logic              fill_req,
  input logic              wb_full,
  input logic              wb_push,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              hold_v,
  input logic              wb_pend
);
  p_one_pop_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_ret_pop, wr_ret_pop, chain_pop}));
  p_chain_first_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_ret_pop || wr_ret_pop) |-> !chain_valid);
  p_read_first_r2: assert property (@(posedge clk) disable iff (rst)
    wr_ret_pop |-> !rd_ret_valid);
  p_no_pop_held_r2: assert property (@(posedge clk) disable iff (rst)
    hold_v |-> !(rd_ret_pop || wr_ret_pop || chain_pop));
  p_notify_pop_r3: assert property (@(posedge clk) disable iff (rst)
    notify_valid |-> (rd_ret_pop || wr_ret_pop));
  p_no_refill_r7: assert property (@(posedge clk) disable iff (rst)
    wb_pend |-> (!fill_req && !reply_push));
  p_wb_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (wb_pend && wb_full) |=> (wb_pend && $stable(wb_addr)));
  p_wb_needs_hold_r8: assert property (@(posedge clk) disable iff (rst)
    wb_pend |-> hold_v);
  p_no_reply_ovf_r9: assert property (@(posedge clk) disable iff (rst)
    reply_push |-> !reply_full);
  p_no_wb_ovf_r9: assert property (@(posedge clk) disable iff (rst)
    wb_push |-> !wb_full);
endmodule

bind fill_wb_seq fwseq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rd_ret_valid (rd_ret_valid),
  .rd_ret_pop   (rd_ret_pop),
  .wr_ret_pop   (wr_ret_pop),
  .chain_valid  (chain_valid),
  .chain_pop    (chain_pop),
  .notify_valid (notify_valid),
  .reply_full   (reply_full),
  .reply_push   (reply_push),
  .fill_req     (fill_req),
  .wb_full      (wb_full),
  .wb_push      (wb_push),
  .wb_addr      (wb_addr),
  .hold_v       (hold_v),
  .wb_pend      (wb_pend)
);

// File: tb/fill_wb_seq_bench.sv
`timescale 1ns/1ps
module fill_wb_seq_bench;
  localparam int AW = 32;
  localparam int IW = 6;
  localparam int LB = 128;
  localparam int SW = $clog2(LB) + 1;

  typedef struct packed {
    logic [IW-1:0] id;
    logic [AW-1:0] addr;
    logic          wr;
  } ent_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic rd_ret_valid, wr_ret_valid, chain_valid, chain_wr;
  logic [IW-1:0] rd_ret_id, wr_ret_id, chain_id;
  logic [AW-1:0] rd_ret_addr, wr_ret_addr, chain_addr;
  logic rd_ret_pop, wr_ret_pop, chain_pop;
  logic notify_valid, notify_hit;
  logic [AW-1:0] notify_addr;
  logic reply_full = 1'b0, reply_push, reply_wr;
  logic [IW-1:0] reply_id;
  logic [AW-1:0] reply_addr;
  logic fill_req;
  logic [AW-1:0] fill_addr;
  logic evict_en = 1'b0;
  logic [AW-1:0] evict_val = '0;
  logic wb_full = 1'b0, wb_push, wb_write;
  logic [AW-1:0] wb_addr;
  logic [SW-1:0] wb_size;
  logic done_valid;
  logic [IW-1:0] done_id;
  logic hit_en = 1'b0;
  logic [AW-1:0] hit_line = '0;

  assign notify_hit = notify_valid && hit_en && (notify_addr[AW-1:7] == hit_line[AW-1:7]);

  fill_wb_seq #(.ADDR_W(AW), .ID_W(IW), .LINE_BYTES(LB)) u_fill_wb_seq (
    .clk(clk), .rst(rst),
    .rd_ret_valid(rd_ret_valid), .rd_ret_id(rd_ret_id), .rd_ret_addr(rd_ret_addr), .rd_ret_pop(rd_ret_pop),
    .wr_ret_valid(wr_ret_valid), .wr_ret_id(wr_ret_id), .wr_ret_addr(wr_ret_addr), .wr_ret_pop(wr_ret_pop),
    .chain_valid(chain_valid), .chain_id(chain_id), .chain_addr(chain_addr), .chain_wr(chain_wr),
    .chain_pop(chain_pop),
    .notify_valid(notify_valid), .notify_addr(notify_addr), .notify_hit(notify_hit),
    .reply_full(reply_full), .reply_push(reply_push), .reply_id(reply_id), .reply_addr(reply_addr),
    .reply_wr(reply_wr),
    .fill_req(fill_req), .fill_addr(fill_addr),
    .evict_valid(evict_en), .evict_addr(evict_val),
    .wb_full(wb_full), .wb_push(wb_push), .wb_addr(wb_addr), .wb_size(wb_size), .wb_write(wb_write),
    .done_valid(done_valid), .done_id(done_id)
  );

  ent_t rd_q[$], wr_q[$], ch_q[$], exp_q[$], pend_chain[$];
  int total = 0, bad = 0;
  int n_reply, n_fill, n_wb, n_done, n_notify, n_pop;
  logic [AW-1:0] last_fill, last_wb, last_notify;
  logic [SW-1:0] last_size;
  logic last_wbw;
  logic [IW-1:0] last_done;

  task automatic refresh();
    rd_ret_valid = rd_q.size() > 0;
    rd_ret_id    = rd_ret_valid ? rd_q[0].id : '0;
    rd_ret_addr  = rd_ret_valid ? rd_q[0].addr : '0;
    wr_ret_valid = wr_q.size() > 0;
    wr_ret_id    = wr_ret_valid ? wr_q[0].id : '0;
    wr_ret_addr  = wr_ret_valid ? wr_q[0].addr : '0;
    chain_valid  = ch_q.size() > 0;
    chain_id     = chain_valid ? ch_q[0].id : '0;
    chain_addr   = chain_valid ? ch_q[0].addr : '0;
    chain_wr     = chain_valid ? ch_q[0].wr : 1'b0;
  endtask

  task automatic check(string r, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_reply = 0; n_fill = 0; n_wb = 0; n_done = 0; n_notify = 0; n_pop = 0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  function automatic ent_t mk(int id, logic [AW-1:0] a, logic w);
    ent_t e;
    e.id = IW'(id); e.addr = a; e.wr = w;
    return e;
  endfunction

  // monitor and queue model: observe at negedge, commit after the edge
  initial begin
    logic p_rd, p_wr, p_ch, p_hit;
    ent_t e;
    clear_counts();
    forever begin
      @(negedge clk);
      p_rd = rd_ret_pop; p_wr = wr_ret_pop; p_ch = chain_pop;
      p_hit = notify_valid && notify_hit;
      if (p_rd || p_wr || p_ch) n_pop++;
      if (notify_valid) begin n_notify++; last_notify = notify_addr; end
      if (reply_push) begin
        n_reply++;
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R4 unexpected reply actual=%0h expected=none", reply_id);
        end else begin
          e = exp_q.pop_front();
          check("R4 reply id", reply_id, e.id);
          check("R4 reply addr", reply_addr, e.addr);
          check("R6 reply wr", reply_wr, e.wr);
        end
      end
      if (fill_req) begin n_fill++; last_fill = fill_addr; end
      if (wb_push) begin n_wb++; last_wb = wb_addr; last_size = wb_size; last_wbw = wb_write; end
      if (done_valid) begin n_done++; last_done = done_id; end
      @(posedge clk);
      #1;
      if (p_rd) void'(rd_q.pop_front());
      if (p_wr) void'(wr_q.pop_front());
      if (p_ch) void'(ch_q.pop_front());
      if (p_hit) begin
        foreach (pend_chain[k]) ch_q.push_back(pend_chain[k]);
        pend_chain.delete();
      end
      refresh();
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=<5000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    refresh();
    // R1: a read waits in its queue during reset
    rd_q.push_back(mk(5, 32'h1234_5678, 1'b0));
    exp_q.push_back(mk(5, 32'h1234_5678, 1'b0));
    refresh();
    step(2);
    @(negedge clk);
    check("R1 no pop in reset", rd_ret_pop, 0);
    check("R1 no reply in reset", reply_push, 0);
    @(posedge clk); #2;
    clear_counts();
    rst = 1'b0;
    // R4: plain read, no eviction
    step(8);
    check("R4 reply count", n_reply, 1);
    check("R4 fill count", n_fill, 1);
    check("R4 fill aligned", last_fill, 32'h1234_5600);
    check("R7 no writeback", n_wb, 0);
    check("R8 done count", n_done, 1);
    check("R8 done id", last_done, 5);
    // R6: write return
    clear_counts();
    wr_q.push_back(mk(9, 32'h0000_4444, 1'b1));
    exp_q.push_back(mk(9, 32'h0000_4444, 1'b1));
    refresh();
    step(8);
    check("R6 reply count", n_reply, 1);
    check("R6 no fill", n_fill, 0);
    check("R6 done id", last_done, 9);
    // R2: chain beats read beats write
    clear_counts();
    rd_q.push_back(mk(1, 32'h0000_1000, 1'b0));
    wr_q.push_back(mk(2, 32'h0000_2000, 1'b1));
    ch_q.push_back(mk(3, 32'h0000_3000, 1'b0));
    exp_q.push_back(mk(3, 32'h0000_3000, 1'b0));
    exp_q.push_back(mk(1, 32'h0000_1000, 1'b0));
    exp_q.push_back(mk(2, 32'h0000_2000, 1'b1));
    refresh();
    step(14);
    check("R2 replies", n_reply, 3);
    check("R2 pops", n_pop, 3);
    check("R2 last done", last_done, 2);
    // R3: memory return that activates a merge chain
    clear_counts();
    hit_en = 1'b1;
    hit_line = 32'h0055_0000;
    rd_q.push_back(mk(4, 32'h0055_0010, 1'b0));
    pend_chain.push_back(mk(11, 32'h0055_0020, 1'b0));
    pend_chain.push_back(mk(12, 32'h0055_0040, 1'b1));
    exp_q.push_back(mk(11, 32'h0055_0020, 1'b0));
    exp_q.push_back(mk(12, 32'h0055_0040, 1'b1));
    refresh();
    step(12);
    hit_en = 1'b0;
    check("R3 notify count", n_notify, 1);
    check("R3 notify addr", last_notify, 32'h0055_0010);
    check("R3 replies from chain", n_reply, 2);
    check("R3 fills", n_fill, 1);
    check("R3 done count", n_done, 2);
    // R5: reply queue full stalls the held read
    clear_counts();
    reply_full = 1'b1;
    rd_q.push_back(mk(20, 32'h0000_7700, 1'b0));
    rd_q.push_back(mk(21, 32'h0000_8800, 1'b0));
    exp_q.push_back(mk(20, 32'h0000_7700, 1'b0));
    exp_q.push_back(mk(21, 32'h0000_8800, 1'b0));
    refresh();
    step(6);
    check("R5 no reply while full", n_reply, 0);
    check("R5 no fill while full", n_fill, 0);
    check("R2 single held pop", n_pop, 1);
    reply_full = 1'b0;
    step(10);
    check("R5 replies after stall", n_reply, 2);
    check("R5 done after stall", n_done, 2);
    // R7/R8: eviction with writeback queue full
    clear_counts();
    evict_en = 1'b1;
    evict_val = 32'hABCD_EF12;
    wb_full = 1'b1;
    rd_q.push_back(mk(30, 32'h0000_9900, 1'b0));
    exp_q.push_back(mk(30, 32'h0000_9900, 1'b0));
    refresh();
    step(8);
    check("R7 reply once", n_reply, 1);
    check("R7 fill once", n_fill, 1);
    check("R9 no wb while full", n_wb, 0);
    check("R8 not released", n_done, 0);
    wb_full = 1'b0;
    step(5);
    evict_en = 1'b0;
    check("R7 wb count", n_wb, 1);
    check("R7 wb addr", last_wb, 32'hABCD_EF00);
    check("R7 wb size", last_size, LB);
    check("R7 wb write", last_wbw, 1);
    check("R7 reply not repeated", n_reply, 1);
    check("R7 fill not repeated", n_fill, 1);
    check("R8 released", n_done, 1);
    check("R8 done id", last_done, 30);
    check("R4 all replies seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule